// File: doc/BRIEF.md
# Saturating Pairwise Multiply-Accumulate Vector Unit

This unit works on a 128-bit vector split into signed elements of 8, 16 or 32 bits. Adjacent elements are handled in pairs. Each pair yields one result: the sum of two signed products, doubled, with an optional rounding constant added. That value is clamped to the signed range of twice the element width, and the upper half is kept. The result goes into exactly one lane of the pair, the lower lane in the straight pairing and the upper lane in the crossed pairing. The other lane of the destination passes through unchanged.

A caller presents both source vectors, the old destination vector, a byte-granular write predicate and the mode controls, then pulses `start_i` for one cycle. On the next rising edge the merged destination and the sticky saturation flag are registered, and `done_o` pulses high for that one cycle. The flag is cleared only by reset.

Top module: `pair_satmac_top`

## Requirements
- R1: While reset is asserted and after reset is released, `vec_o` is all zero and `sat_o` and `done_o` are 0 until the first start.
- R2: `done_o` is 1 in exactly the cycle after a cycle with `start_i` high. In a cycle that follows no start, `vec_o` and `sat_o` keep their values.
- R3: `size_i` selects the element width: 0 selects 8 bits, 1 selects 16 bits, and 2 or 3 selects 32 bits. Element e occupies bits [e*W+W-1 : e*W]. With `cross_i`=0, every even lane e receives the upper W bits of clamp(2*(A[e]*B[e] + A[e+1]*B[e+1]) + k).
- R4: With `cross_i`=1, every odd lane e receives the upper W bits of clamp(2*(A[e]*B[e-1] + A[e-1]*B[e]) + k).
- R5: Lanes that the current pairing does not compute (odd lanes when `cross_i`=0, even lanes when `cross_i`=1) are loaded from `dst_i` unchanged.
- R6: Predicate bit i covers byte i, which is bits [8i+7:8i]. A byte whose predicate bit is 0 is loaded from `dst_i`, even when it belongs to a computed lane.
- R7: The rounding term k is 0 when `round_i`=0 and 2^(W-1) when `round_i`=1.
- R8: clamp() limits to the range -2^(2W-1) .. 2^(2W-1)-1 after the full sum, doubling and rounding. A clamped lane therefore reads 0x7F..F on positive overflow and 0x80..0 on negative overflow, for example 0x7FFFFFFF and 0x80000000 at 32 bits.
- R9: `sat_o` becomes 1 after a start in which a computed lane was clamped and the predicate bit of that lane's lowest byte was 1. A clamped lane whose lowest-byte predicate bit is 0 does not set it.
- R10: Once `sat_o` is 1, later operations never clear it. Only reset clears it.
- R11: When every element of both sources holds the most negative value, every computed lane with its lowest-byte predicate set clamps to the positive maximum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle operation request |
| size_i | input | 2 | Element width select |
| cross_i | input | 1 | Crossed pairing, results to odd lanes |
| round_i | input | 1 | Add rounding term before clamping |
| src_a_i | input | 128 | First source vector |
| src_b_i | input | 128 | Second source vector |
| dst_i | input | 128 | Previous destination vector |
| pred_i | input | 16 | Per-byte write predicate |
| vec_o | output | 128 | Registered merged destination |
| sat_o | output | 1 | Sticky saturation flag |
| done_o | output | 1 | Result-valid pulse |

## Verification
The hardest state to reach is a lane whose sum only just crosses the clamp limits, together with a predicate that writes some bytes of the lane but not its lowest byte. Random operands almost never produce these cases. The stimulus therefore mixes random vectors with vectors filled with most-negative and near-extreme values. It also runs a directed case where the predicate hides exactly the lowest byte of each clamped lane while the upper bytes are still written. Rounding is exercised with a product that sits exactly at the half-step below the kept half.

// File: rtl/pair_satmac_pkg.sv
package pair_satmac_pkg;
  typedef logic [1:0] esz_t;
  localparam esz_t SZ_B = 2'd0;
  localparam esz_t SZ_H = 2'd1;
  localparam esz_t SZ_W = 2'd2;
  localparam int NUM_SZ = 3;
  localparam int BASE_W = 8;
endpackage

// File: rtl/pair_satmac_pair.sv
module pair_satmac_pair #(
  parameter int EW = 8
) (
  input  logic [EW-1:0] a_lo_i,
  input  logic [EW-1:0] a_hi_i,
  input  logic [EW-1:0] b_lo_i,
  input  logic [EW-1:0] b_hi_i,
  input  logic          cross_i,
  input  logic          round_i,
  output logic [EW-1:0] res_o,
  output logic          sat_o
);
  localparam int PW = 2 * EW;
  localparam int AW = PW + 3;
  localparam logic signed [AW-1:0] SMAX = $signed({{(AW-PW+1){1'b0}}, {(PW-1){1'b1}}});
  localparam logic signed [AW-1:0] SMIN = $signed({{(AW-PW+1){1'b1}}, {(PW-1){1'b0}}});

  logic signed [EW-1:0] op_b0, op_b1;
  logic signed [PW-1:0] prod0, prod1;
  logic signed [AW-1:0] ext0, ext1, dbl, rc, acc;
  logic                 over_hi, over_lo;
  logic                 unused_lo;

  always_comb begin
    op_b0 = cross_i ? $signed(b_hi_i) : $signed(b_lo_i);
    op_b1 = cross_i ? $signed(b_lo_i) : $signed(b_hi_i);
    prod0 = $signed(a_lo_i) * op_b0;
    prod1 = $signed(a_hi_i) * op_b1;
    ext0  = $signed({{(AW-PW){prod0[PW-1]}}, prod0});
    ext1  = $signed({{(AW-PW){prod1[PW-1]}}, prod1});
    dbl   = (ext0 + ext1) <<< 1;
    rc    = round_i ? $signed({{(AW-EW){1'b0}}, 1'b1, {(EW-1){1'b0}}}) : '0;
    acc   = dbl + rc;
    over_hi = acc > SMAX;
    over_lo = acc < SMIN;
    sat_o   = over_hi | over_lo;
    if (over_hi)      res_o = {1'b0, {(EW-1){1'b1}}};
    else if (over_lo) res_o = {1'b1, {(EW-1){1'b0}}};
    else              res_o = acc[PW-1:EW];
  end

  assign unused_lo = ^{acc[EW-1:0], acc[AW-1:PW]};

  // R8: a clamped lane always reads one of the two extremes
  always_comb begin
    if (sat_o) begin
      p_clamp_extreme_r8: assert (res_o[EW-2:0] == {(EW-1){~res_o[EW-1]}})
        else $error("clamped lane not at an extreme");
    end
  end
endmodule

// File: rtl/pair_satmac_lanes.sv
module pair_satmac_lanes #(
  parameter int VW = 128,
  parameter int EW = 8
) (
  input  logic [VW-1:0]   src_a_i,
  input  logic [VW-1:0]   src_b_i,
  input  logic            cross_i,
  input  logic            round_i,
  output logic [VW-1:0]   res_o,
  output logic [VW/8-1:0] wr_o,
  output logic [VW/8-1:0] sat_o
);
  localparam int NE = VW / EW;
  localparam int NP = NE / 2;
  localparam int EB = EW / 8;

  for (genvar k = 0; k < NP; k++) begin : g_pair
    logic [EW-1:0] res_k;
    logic          sat_k;

    pair_satmac_pair #(.EW(EW)) i_pair (
      .a_lo_i (src_a_i[(2*k)*EW +: EW]),
      .a_hi_i (src_a_i[(2*k+1)*EW +: EW]),
      .b_lo_i (src_b_i[(2*k)*EW +: EW]),
      .b_hi_i (src_b_i[(2*k+1)*EW +: EW]),
      .cross_i(cross_i),
      .round_i(round_i),
      .res_o  (res_k),
      .sat_o  (sat_k)
    );

    assign res_o[(2*k)*EW +: EW]   = res_k;
    assign res_o[(2*k+1)*EW +: EW] = res_k;
    assign wr_o[(2*k)*EB +: EB]    = {EB{~cross_i}};
    assign wr_o[(2*k+1)*EB +: EB]  = {EB{cross_i}};
    assign sat_o[(2*k)*EB]         = sat_k & ~cross_i;
    assign sat_o[(2*k+1)*EB]       = sat_k & cross_i;
    if (EB > 1) begin : g_upper
      assign sat_o[(2*k)*EB+1 +: EB-1]   = '0;
      assign sat_o[(2*k+1)*EB+1 +: EB-1] = '0;
    end
  end
endmodule

// File: rtl/pair_satmac_merge.sv
module pair_satmac_merge
  import pair_satmac_pkg::*;
#(
  parameter int VW = 128
) (
  input  esz_t                         size_i,
  input  logic [VW-1:0]                dst_i,
  input  logic [VW/8-1:0]              pred_i,
  input  logic [NUM_SZ-1:0][VW-1:0]    res_i,
  input  logic [NUM_SZ-1:0][VW/8-1:0]  wr_i,
  input  logic [NUM_SZ-1:0][VW/8-1:0]  sat_i,
  output logic [VW-1:0]                vec_o,
  output logic                         sat_hit_o
);
  localparam int NB = VW / 8;

  logic [VW-1:0] res_sel;
  logic [NB-1:0] wr_sel, sat_sel, keep;

  always_comb begin
    case (size_i)
      SZ_B:    begin res_sel = res_i[0]; wr_sel = wr_i[0]; sat_sel = sat_i[0]; end
      SZ_H:    begin res_sel = res_i[1]; wr_sel = wr_i[1]; sat_sel = sat_i[1]; end
      default: begin res_sel = res_i[2]; wr_sel = wr_i[2]; sat_sel = sat_i[2]; end
    endcase
    keep      = wr_sel & pred_i;
    sat_hit_o = |(sat_sel & pred_i);
    for (int b = 0; b < NB; b++) begin
      vec_o[b*8 +: 8] = keep[b] ? res_sel[b*8 +: 8] : dst_i[b*8 +: 8];
    end
  end

  // R9: a saturation hit comes only from a lane whose lowest byte is written
  always_comb begin
    if (sat_hit_o) begin
      p_hit_written_r9: assert (|(keep & sat_sel))
        else $error("saturation reported for an unwritten lane");
    end
  end
endmodule

// File: rtl/pair_satmac_top.sv
module pair_satmac_top
  import pair_satmac_pkg::*;
#(
  parameter int VW = 128
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [1:0]    size_i,
  input  logic          cross_i,
  input  logic          round_i,
  input  logic [VW-1:0] src_a_i,
  input  logic [VW-1:0] src_b_i,
  input  logic [VW-1:0] dst_i,
  input  logic [VW/8-1:0] pred_i,
  output logic [VW-1:0] vec_o,
  output logic          sat_o,
  output logic          done_o
);
  localparam int NB = VW / 8;

  logic [NUM_SZ-1:0][VW-1:0] res_all;
  logic [NUM_SZ-1:0][NB-1:0] wr_all, sat_all;
  logic [VW-1:0]             merged;
  logic                      sat_hit;

  for (genvar g = 0; g < NUM_SZ; g++) begin : g_size
    pair_satmac_lanes #(.VW(VW), .EW(BASE_W << g)) i_lanes (
      .src_a_i(src_a_i),
      .src_b_i(src_b_i),
      .cross_i(cross_i),
      .round_i(round_i),
      .res_o  (res_all[g]),
      .wr_o   (wr_all[g]),
      .sat_o  (sat_all[g])
    );
  end

  pair_satmac_merge #(.VW(VW)) i_merge (
    .size_i   (size_i),
    .dst_i    (dst_i),
    .pred_i   (pred_i),
    .res_i    (res_all),
    .wr_i     (wr_all),
    .sat_i    (sat_all),
    .vec_o    (merged),
    .sat_hit_o(sat_hit)
  );

  logic [VW-1:0] vec_q, vec_d;
  logic          sat_q, sat_d, done_q, done_d;

  always_comb begin
    vec_d  = vec_q;
    sat_d  = sat_q;
    done_d = start_i;
    if (start_i) begin
      vec_d = merged;
      sat_d = sat_q | sat_hit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_q  <= '0;
      sat_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      vec_q  <= vec_d;
      sat_q  <= sat_d;
      done_q <= done_d;
    end
  end

  assign vec_o  = vec_q;
  assign sat_o  = sat_q;
  assign done_o = done_q;

  p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> done_o) else $error("done missing after start");
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> (!done_o && $stable(vec_o) && $stable(sat_o)))
    else $error("state moved without start");
  p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sat_o |=> sat_o) else $error("saturation flag cleared");

  for (genvar b = 0; b < NB; b++) begin : g_byte_chk
    p_pred_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !pred_i[b]) |=> vec_o[b*8 +: 8] == $past(dst_i[b*8 +: 8]))
      else $error("masked byte overwritten");
    p_unsel_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && size_i == SZ_B && ((b % 2) != 32'(cross_i)))
      |=> vec_o[b*8 +: 8] == $past(dst_i[b*8 +: 8]))
      else $error("uncomputed lane overwritten");
  end
endmodule

// File: tb/test_pair_satmac_top.sv
`timescale 1ns/1ps
module test_pair_satmac_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start_i = 1'b0;
  logic [1:0]   size_i = '0;
  logic         cross_i = 1'b0, round_i = 1'b0;
  logic [127:0] src_a_i = '0, src_b_i = '0, dst_i = '0;
  logic [15:0]  pred_i = '0;
  logic [127:0] vec_o;
  logic         sat_o, done_o;

  int n_chk = 0;
  int n_fail = 0;
  bit exp_sat = 1'b0;

  always #2.5 clk = ~clk;

  pair_satmac_top i_pair_satmac_top (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .size_i(size_i),
    .cross_i(cross_i), .round_i(round_i), .src_a_i(src_a_i),
    .src_b_i(src_b_i), .dst_i(dst_i), .pred_i(pred_i),
    .vec_o(vec_o), .sat_o(sat_o), .done_o(done_o)
  );

  function automatic logic signed [71:0] elem(input logic [127:0] v, input int e, input int ew);
    logic [127:0] t;
    logic signed [71:0] r;
    t = v >> (e * ew);
    for (int i = 0; i < 72; i++) r[i] = (i < ew) ? t[i] : t[ew-1];
    return r;
  endfunction

  function automatic void ref_op(input logic [127:0] a, b, d, input logic [15:0] p,
                                 input logic [1:0] sz, input bit x, input bit rnd,
                                 output logic [127:0] q, output bit s);
    int eb, ew, ne;
    logic signed [71:0] pa, pb, pc, pd, acc, lim_hi, lim_lo, res;
    bit clamp;
    eb = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    ew = eb * 8;
    ne = 16 / eb;
    q = d;
    s = 1'b0;
    for (int e = 0; e < ne; e++) begin
      if ((e % 2) == int'(x)) begin
        if (!x) begin
          pa = elem(a, e, ew);   pb = elem(b, e, ew);
          pc = elem(a, e+1, ew); pd = elem(b, e+1, ew);
        end else begin
          pa = elem(a, e, ew);   pb = elem(b, e-1, ew);
          pc = elem(a, e-1, ew); pd = elem(b, e, ew);
        end
        acc = (pa * pb + pc * pd) * 2;
        if (rnd) acc = acc + (72'sd1 <<< (ew - 1));
        lim_hi = (72'sd1 <<< (2*ew - 1)) - 1;
        lim_lo = -(72'sd1 <<< (2*ew - 1));
        clamp = 1'b0;
        if (acc > lim_hi) begin acc = lim_hi; clamp = 1'b1; end
        if (acc < lim_lo) begin acc = lim_lo; clamp = 1'b1; end
        res = acc >>> ew;
        for (int k = 0; k < eb; k++)
          if (p[e*eb + k])
            for (int i = 0; i < 8; i++) q[(e*eb + k)*8 + i] = res[k*8 + i];
        if (clamp && p[e*eb]) s = 1'b1;
      end
    end
  endfunction

  task automatic check_vec(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s vec actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_bit(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    exp_sat = 1'b0;
  endtask

  task automatic run_op(input string tag, input logic [127:0] a, b, d, input logic [15:0] p,
                        input logic [1:0] sz, input bit x, input bit rnd);
    logic [127:0] q;
    bit s;
    ref_op(a, b, d, p, sz, x, rnd, q, s);
    exp_sat = exp_sat | s;
    @(negedge clk);
    src_a_i = a; src_b_i = b; dst_i = d; pred_i = p;
    size_i = sz; cross_i = x; round_i = rnd; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check_bit({tag, " R2 done"}, done_o, 1'b1);
    check_vec(tag, vec_o, q);
    check_bit({tag, " R9 flag"}, sat_o, exp_sat);
  endtask

  initial begin
    #(5ns * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [127:0] hold_v;
    void'($urandom(32'd4242));
    #1;
    check_vec("R1 reset", vec_o, '0);
    check_bit("R1 reset sat", sat_o, 1'b0);
    check_bit("R1 reset done", done_o, 1'b0);
    do_reset();
    check_vec("R1 after release", vec_o, '0);

    // R11: most negative everywhere, all sizes and both pairings
    for (int sz = 0; sz < 3; sz++)
      for (int x = 0; x < 2; x++) begin
        do_reset();
        run_op("R11 R8 all-min", {16{8'h80}} & {(sz == 0) ? {16{8'h80}} : (sz == 1) ? {8{16'h8000}} : {4{32'h80000000}}},
               (sz == 0) ? {16{8'h80}} : (sz == 1) ? {8{16'h8000}} : {4{32'h80000000}},
               {16{8'h5A}}, 16'hFFFF, 2'(sz), bit'(x), bit'(x));
      end

    // R9: clamped lanes with lowest byte hidden do not set the flag
    do_reset();
    run_op("R9 hidden low byte", {8{16'h8000}}, {8{16'h8000}}, {16{8'hC3}}, ~16'h1111, 2'd1, 1'b0, 1'b0);
    check_bit("R9 no flag", sat_o, 1'b0);

    // R10: flag sticks through a benign op
    run_op("R8 set flag", {4{32'h80000000}}, {4{32'h80000000}}, '0, 16'hFFFF, 2'd2, 1'b0, 1'b0);
    run_op("R10 benign", '0, '0, {16{8'h11}}, 16'hFFFF, 2'd0, 1'b0, 1'b0);
    check_bit("R10 sticky", sat_o, 1'b1);

    // R7: product exactly at the half step
    do_reset();
    run_op("R7 no round", 128'h0100_0040, 128'h0100_0040, '0, 16'hFFFF, 2'd1, 1'b0, 1'b0);
    run_op("R7 round", {112'd0, 16'h0040}, {112'd0, 16'h0100}, '0, 16'hFFFF, 2'd1, 1'b0, 1'b1);
    check_vec("R7 lane0 one", vec_o & 128'hFFFF, 128'h1);

    // R8: negative overflow at 32 bits
    run_op("R8 neg clamp", {4{32'h7FFFFFFF}}, {4{32'h80000000}}, '0, 16'hFFFF, 2'd2, 1'b1, 1'b1);
    run_op("R3 size3 as word", {4{32'h12345678}}, {4{32'h0FEDCBA9}}, '1, 16'hFFFF, 2'd3, 1'b0, 1'b1);

    // R2: idle cycle holds state
    hold_v = vec_o;
    @(negedge clk);
    check_bit("R2 idle done", done_o, 1'b0);
    check_vec("R2 idle hold", vec_o, hold_v);

    // Random mix, R3 R4 R5 R6 R7 R8
    for (int it = 0; it < 600; it++) begin
      logic [127:0] a, b, d;
      logic [1:0] sz;
      int sel;
      for (int w = 0; w < 4; w++) begin
        a[w*32 +: 32] = $urandom; b[w*32 +: 32] = $urandom; d[w*32 +: 32] = $urandom;
      end
      sel = $urandom % 4;
      if (sel == 0) begin a = a | {16{8'h80}}; b = b | {16{8'h80}}; end
      if (sel == 1) begin a = {16{8'h80}} ^ (a & {16{8'h01}}); b = {16{8'h80}}; end
      sz = 2'($urandom % 4);
      run_op((it % 2) ? "R4 R5 R6 random" : "R3 R5 R6 random", a, b, d,
             16'($urandom), sz, bit'(it % 2), bit'($urandom % 2));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule